// File: doc/BRIEF.md
# Serial Converter Read Port with Period Timeout

This block is the serial slave side of a data converter. A master clocks 8-bit commands in on the data input. When the command is the read code, the block waits for a fixed response delay and then shifts the latest 24-bit conversion result out, MSB first. The active-low chip-select can be pulsed for every frame or held low permanently. Raising it always returns the frame logic to the start of a command, and this also lets the master abandon a read early.

A pulse input marks the start of every conversion period. On each pulse the block loads a new result, unless a read is in progress, and drives its active-low data-ready line low. Data-ready goes high again when the first result bit leaves the block, and it is held high during power-down. When chip-select is tied low, a glitch on the serial clock can leave the slave one bit ahead of the master. To recover from this, the frame logic restarts once the serial clock has stayed low for a set number of conversion periods, 32 by default.

Top module: `conv_spi_slave`

## Requirements
- R1: After reset, dout_o is 0 and drdy_no is 1.
- R2: While converting, every conv_tick_i pulse that loads a result drives drdy_no high for one cycle and then low. drdy_no falls only after such a load.
- R3: Commands are 8 bits, MSB first, sampled on falling edges of sclk_i. After the read code 0x01 and a response delay, the 24-bit result appears on dout_o MSB first. Each bit changes on a rising edge of sclk_i.
- R4: drdy_no returns high when the first result bit is shifted out.
- R5: A conv_tick_i pulse during the response delay or the data phase does not replace the result being read. The frame shows the value latched before the command completed.
- R6: cs_ni high restarts the frame at once. This covers both a partly received command and a read stopped after 16 bits. The next read works normally.
- R7: A command other than 0x01 produces no data, and dout_o stays 0 outside the data phase.
- R8: With cs_ni tied low, one extra sclk_i pulse puts the command bit count one bit out of step. The misalignment persists if sclk_i stays low for fewer than TMO_PERIODS conversion periods.
- R9: If sclk_i stays low for TMO_PERIODS consecutive conversion periods, the frame restarts at the first command bit.
- R10: While pwrdn_i is 1, drdy_no stays high and no result is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Chip-select, active low |
| din_i | input | 1 | Serial command input |
| dout_o | output | 1 | Serial result output |
| conv_tick_i | input | 1 | One-cycle pulse per conversion period |
| pwrdn_i | input | 1 | Power-down, stops conversions |
| result_i | input | 24 | New conversion result |
| drdy_no | output | 1 | Data-ready, active low |

## Verification
The serial inputs pass through two synchronizer stages and one edge register. As a result, dout_o settles about three system clocks after an sclk_i rise, and the bench samples it eight clocks later, just before it lowers sclk_i. After a command, the data phase begins RESP_CYC plus three clocks after the eighth falling edge, so the bench waits 40 clocks before its first data clock. drdy_no falls two clocks after a loading tick. The bench therefore checks it five clocks after the tick, and checks the high level after the first data bit has been sampled. The timeout tests count whole tick periods with sclk_i low: 20 periods to show that the misalignment persists, and 34 to show that it is cleared.

// File: rtl/conv_spi_pkg.sv
package conv_spi_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_WAIT, ST_DATA} frame_st_e;
endpackage

// File: rtl/conv_spi_sync.sv
module conv_spi_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic din_i,
  output logic cs_n_o,
  output logic din_o,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] m1_q, m2_q;
  logic       sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q     <= 3'b100;
      m2_q     <= 3'b100;
      sclk_d_q <= 1'b0;
    end else begin
      m1_q     <= {cs_ni, sclk_i, din_i};
      m2_q     <= m1_q;
      sclk_d_q <= m2_q[1];
    end
  end

  assign cs_n_o = m2_q[2];
  assign sclk_o = m2_q[1];
  assign din_o  = m2_q[0];
  assign rise_o = m2_q[1] & ~sclk_d_q & ~m2_q[2];
  assign fall_o = ~m2_q[1] & sclk_d_q & ~m2_q[2];
endmodule

// File: rtl/conv_spi_tmo.sv
module conv_spi_tmo #(
  parameter int TMO_PERIODS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int TMO_W = $clog2(TMO_PERIODS + 1);
  logic [TMO_W-1:0] cnt_q;

  assign fire_o = tick_i & ~clr_i & (cnt_q == TMO_W'(TMO_PERIODS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (fire_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/conv_spi_frame.sv
module conv_spi_frame
  import conv_spi_pkg::*;
#(
  parameter int          CMD_W    = 8,
  parameter int          DATA_W   = 24,
  parameter int          RESP_CYC = 16,
  parameter logic [7:0]  RD_CODE  = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] res_i,
  output frame_st_e         st_o,
  output logic [$clog2(DATA_W)-1:0] bcnt_o,
  output logic              first_bit_o,
  output logic              dout_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int DLY_W = $clog2(RESP_CYC + 1);

  frame_st_e          st_q;
  logic [CNT_W-1:0]   bcnt_q;
  logic [CMD_W-2:0]   cmd_q;
  logic [CMD_W-1:0]   cmd_nxt;
  logic [DLY_W-1:0]   dly_q;
  logic [DATA_W-1:0]  sh_q;
  logic               dout_q;

  assign cmd_nxt     = {cmd_q, din_i};
  assign first_bit_o = (st_q == ST_DATA) & rise_i & (bcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      bcnt_q <= '0;
      cmd_q  <= '0;
      dly_q  <= '0;
      sh_q   <= '0;
      dout_q <= 1'b0;
    end else if (restart_i) begin
      st_q   <= ST_CMD;
      bcnt_q <= '0;
      dly_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_CMD: if (fall_i) begin
          cmd_q <= cmd_nxt[CMD_W-2:0];
          if (bcnt_q == CNT_W'(CMD_W - 1)) begin
            bcnt_q <= '0;
            if (cmd_nxt == RD_CODE[CMD_W-1:0]) begin
              st_q  <= ST_WAIT;
              dly_q <= '0;
            end
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          dly_q <= dly_q + 1'b1;
          if (dly_q == DLY_W'(RESP_CYC - 1)) begin
            st_q   <= ST_DATA;
            sh_q   <= res_i;
            bcnt_q <= '0;
          end
        end
        ST_DATA: begin
          if (rise_i) begin
            dout_q <= sh_q[DATA_W-1];
            sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
          end
          if (fall_i) begin
            if (bcnt_q == CNT_W'(DATA_W - 1)) begin
              st_q   <= ST_CMD;
              bcnt_q <= '0;
              dout_q <= 1'b0;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_CMD;
      endcase
    end
  end

  assign st_o   = st_q;
  assign bcnt_o = bcnt_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/conv_spi_drdy.sv
module conv_spi_drdy #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwrdn_i,
  input  logic              busy_i,
  input  logic              first_bit_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] res_o,
  output logic              load_o,
  output logic              drdy_no
);
  logic [DATA_W-1:0] res_q;
  logic              load_q, drdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      load_q <= 1'b0;
      drdy_q <= 1'b1;
    end else if (pwrdn_i) begin
      load_q <= 1'b0;
      drdy_q <= 1'b1;
    end else if (tick_i && !busy_i) begin
      res_q  <= result_i;
      load_q <= 1'b1;
      drdy_q <= 1'b1;
    end else if (load_q) begin
      load_q <= 1'b0;
      drdy_q <= 1'b0;
    end else if (first_bit_i) begin
      drdy_q <= 1'b1;
    end
  end

  assign res_o   = res_q;
  assign load_o  = load_q;
  assign drdy_no = drdy_q;
endmodule

// File: rtl/conv_spi_slave.sv
module conv_spi_slave
  import conv_spi_pkg::*;
#(
  parameter int         DATA_W      = 24,
  parameter int         CMD_W       = 8,
  parameter int         RESP_CYC    = 16,
  parameter int         TMO_PERIODS = 32,
  parameter logic [7:0] RD_CODE     = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  output logic              dout_o,
  input  logic              conv_tick_i,
  input  logic              pwrdn_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              drdy_no
);
  localparam int CNT_W = $clog2(DATA_W);

  logic cs_n_s, din_s, sclk_s, rise, fall, tmo_fire, first_bit, load;
  frame_st_e         st;
  logic [CNT_W-1:0]  bcnt;
  logic [DATA_W-1:0] res_q;

  conv_spi_sync i_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i,
    .cs_n_o(cs_n_s), .din_o(din_s), .sclk_o(sclk_s), .rise_o(rise), .fall_o(fall)
  );

  conv_spi_tmo #(.TMO_PERIODS(TMO_PERIODS)) i_tmo (
    .clk_i, .rst_ni, .clr_i(sclk_s | cs_n_s), .tick_i(conv_tick_i), .fire_o(tmo_fire)
  );

  conv_spi_frame #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .RESP_CYC(RESP_CYC), .RD_CODE(RD_CODE)
  ) i_frame (
    .clk_i, .rst_ni, .restart_i(cs_n_s | tmo_fire), .rise_i(rise), .fall_i(fall),
    .din_i(din_s), .res_i(res_q), .st_o(st), .bcnt_o(bcnt),
    .first_bit_o(first_bit), .dout_o
  );

  conv_spi_drdy #(.DATA_W(DATA_W)) i_drdy (
    .clk_i, .rst_ni, .tick_i(conv_tick_i), .pwrdn_i, .busy_i(st != ST_CMD),
    .first_bit_i(first_bit), .result_i, .res_o(res_q), .load_o(load), .drdy_no
  );
endmodule

// File: rtl/conv_spi_slave_chk.sv
module conv_spi_slave_chk
  import conv_spi_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwrdn_i,
  input logic              drdy_no,
  input logic              dout_o,
  input logic              cs_n_s,
  input logic              tmo_fire,
  input logic              first_bit,
  input logic              load,
  input frame_st_e         st,
  input logic [$clog2(DATA_W)-1:0] bcnt,
  input logic [DATA_W-1:0] res_q
);
  assert_pwrdn_drdy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> drdy_no);
  assert_cs_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> (st == ST_CMD) && (bcnt == '0));
  assert_tmo_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_fire |=> (st == ST_CMD) && (bcnt == '0));
  assert_res_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DATA) |=> $stable(res_q));
  assert_drdy_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_no) |-> $past(load));
  assert_drdy_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_bit |=> drdy_no);
  assert_dout_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_DATA) |-> !dout_o);
endmodule

bind conv_spi_slave conv_spi_slave_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwrdn_i(pwrdn_i), .drdy_no(drdy_no),
  .dout_o(dout_o), .cs_n_s(cs_n_s), .tmo_fire(tmo_fire), .first_bit(first_bit),
  .load(load), .st(st), .bcnt(bcnt), .res_q(res_q)
);

// File: tb/test_conv_spi_slave.sv
module test_conv_spi_slave;
  localparam int HALF = 8;
  localparam int TICK = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, tick = 1'b0, pwrdn = 1'b0;
  logic [23:0] result = 24'h0;
  logic dout, drdy_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic drdy_first;
  logic [23:0] exp_q[$];

  always #10 clk = ~clk;

  conv_spi_slave i_conv_spi_slave (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .dout_o(dout), .conv_tick_i(tick), .pwrdn_i(pwrdn), .result_i(result),
    .drdy_no(drdy_n)
  );

  initial begin
    @(posedge rst_ni);
    forever begin
      repeat (TICK - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic clk_bit(input logic b, output logic d);
    din  = b;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    d    = dout;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // master frame: read command, optional result swap during delay, nbits of data
  task automatic do_read(input int nbits, input bit use_cs, input bit swap,
                         input logic [23:0] swap_val, output logic [23:0] w);
    logic d;
    if (use_cs) begin cs_n = 1'b0; repeat (4) @(negedge clk); end
    for (int i = 7; i >= 0; i--) clk_bit(8'h01 >> i, d);
    if (swap) result = swap_val;
    repeat (40) @(negedge clk);
    w = '0;
    for (int i = 0; i < nbits; i++) begin
      clk_bit(1'b0, d);
      w = {w[22:0], d};
      if (i == 0) drdy_first = drdy_n;
    end
    if (use_cs) begin repeat (4) @(negedge clk); cs_n = 1'b1; repeat (8) @(negedge clk); end
  endtask

  task automatic score(input string req, input logic [23:0] got);
    chk(req, got, exp_q.pop_front());
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge tick);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] w;
    logic d;
    bit pd_bad;
    repeat (5) @(negedge clk);
    // R1 reset values
    chk("R1 dout", {23'b0, dout}, 24'h0);
    chk("R1 drdy", {23'b0, drdy_n}, 24'h1);
    rst_ni = 1'b1;

    result = 24'hA5C31E;
    wait_ticks(2);
    chk("R2 drdy low after tick", {23'b0, drdy_n}, 24'h0);

    // R3 basic read, R4 drdy release
    exp_q.push_back(24'hA5C31E);
    do_read(24, 1, 0, 0, w);
    score("R3 read A", w);
    chk("R4 drdy high after first bit", {23'b0, drdy_first}, 24'h1);

    result = 24'h5A0F81;
    wait_ticks(2);
    exp_q.push_back(24'h5A0F81);
    do_read(24, 1, 0, 0, w);
    score("R3 read B", w);

    // R5 result held while reading
    wait_ticks(1);
    exp_q.push_back(24'h5A0F81);
    do_read(24, 1, 1, 24'h123456, w);
    score("R5 held result", w);

    // R6 16-bit abort then full read
    wait_ticks(2);
    exp_q.push_back(24'h001234);
    do_read(16, 1, 0, 0, w);
    score("R6 16-bit abort", w);
    exp_q.push_back(24'h123456);
    do_read(24, 1, 0, 0, w);
    score("R6 read after abort", w);

    // R6 cs high mid-command
    cs_n = 1'b0; repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, d);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    exp_q.push_back(24'h123456);
    do_read(24, 1, 0, 0, w);
    score("R6 read after partial command", w);

    // R8 cs tied low, one extra pulse misaligns
    cs_n = 1'b0; repeat (4) @(negedge clk);
    clk_bit(1'b0, d);
    exp_q.push_back(24'h0);
    do_read(24, 0, 0, 0, w);
    score("R8 misaligned read", w);
    exp_q.push_back(24'h0);
    do_read(24, 0, 0, 0, w);
    score("R7 R8 still misaligned", w);

    // R8 fewer than 32 idle periods do not recover
    wait_ticks(20);
    exp_q.push_back(24'h0);
    do_read(24, 0, 0, 0, w);
    score("R8 short idle no recovery", w);

    // R9 timeout recovers
    wait_ticks(34);
    exp_q.push_back(24'h123456);
    do_read(24, 0, 0, 0, w);
    score("R9 recovered by timeout", w);
    cs_n = 1'b1;

    // R10 power-down holds drdy high
    pwrdn = 1'b1;
    result = 24'hFFFFFF;
    pd_bad = 0;
    repeat (3 * TICK) begin
      @(negedge clk);
      if (drdy_n !== 1'b1) pd_bad = 1;
    end
    chk("R10 drdy high in power-down", {23'b0, pd_bad}, 24'h0);
    exp_q.push_back(24'h123456);
    do_read(24, 1, 0, 0, w);
    score("R10 no load in power-down", w);
    pwrdn = 1'b0;
    wait_ticks(2);
    chk("R2 drdy low after power-up", {23'b0, drdy_n}, 24'h0);

    finish_run();
  end
endmodule